// File: doc/BRIEF.md
# Pipeline hazard detection and forwarding unit

This unit is the hazard control for a five-stage in-order integer pipeline made of fetch, decode, execute, memory and writeback. It reads the source register numbers of two instructions: the one held in the decode/execute register, which is about to use its operands in execute, and the one in the fetch/decode register. It also reads the destination number, write enable and load flag of each older instruction in flight. From these it drives the bypass selects for both execute operands. It drives one stall request that freezes the program counter and the fetch/decode register and puts a bubble into execute. It also drives the flush strobes that remove wrong-path instructions after a mispredicted branch.

The datapath multiplexers, the register file and the ALU sit outside this block. The unit is combinational apart from one flop. That flop records that the previous cycle stalled, so a single load-use hazard can never cost more than one bubble. A branch mispredict overrides a stall in the same cycle, because the instructions that would have been held are discarded.

Top module: `hazard_unit`

## Requirements
- R1: After reset, with every enable, load flag and mispredict input low, both operand selects are 2'b00 and pc_hold, fd_hold, dx_bubble, fd_flush and dx_flush are all low.
- R2: Each execute operand select, fwd_a for dx_rs1 and fwd_b for dx_rs2, is 2'b10 (execute/memory result) when its source equals xm_rd, xm_we is high and xm_load is low.
- R3: An operand select is 2'b01 (memory/writeback result) when its source equals mw_rd with mw_we high, and R2 does not apply to it. In all other cases it is 2'b00 (register file). The value 2'b11 is never produced.
- R4: When the execute/memory and memory/writeback producers both qualify for the same source, the select is 2'b10, so the younger producer wins.
- R5: A producer whose write enable is low is never selected, whatever its destination number.
- R6: A source or destination of register 0 never causes forwarding or a stall.
- R7: An execute/memory producer with xm_load high is never selected with 2'b10. Its data is not ready until it reaches memory/writeback, so the select falls to 2'b01 or 2'b00 under R3.
- R8: A load-use hazard exists when dx_load and dx_we are high, dx_rd is nonzero and dx_rd equals fd_rs1 or fd_rs2. It raises pc_hold, fd_hold and dx_bubble together in the same cycle.
- R9: A stall lasts at most one cycle. In the cycle after a stall, none of pc_hold, fd_hold or dx_bubble is raised, even if the hazard inputs are unchanged. In the cycle after that, the same inputs stall again.
- R10: br_miss raises fd_flush and dx_flush in the same cycle.
- R11: While br_miss is high, pc_hold, fd_hold and dx_bubble stay low even if a load-use hazard is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dx_rs1 | input | 5 | First source of the instruction entering execute |
| dx_rs2 | input | 5 | Second source of the instruction entering execute |
| fd_rs1 | input | 5 | First source of the instruction in decode |
| fd_rs2 | input | 5 | Second source of the instruction in decode |
| dx_rd | input | 5 | Destination of the instruction in the decode/execute register |
| dx_we | input | 1 | That instruction writes its destination |
| dx_load | input | 1 | That instruction is a load |
| xm_rd | input | 5 | Destination in the execute/memory register |
| xm_we | input | 1 | Execute/memory instruction writes its destination |
| xm_load | input | 1 | Execute/memory instruction is a load |
| mw_rd | input | 5 | Destination in the memory/writeback register |
| mw_we | input | 1 | Memory/writeback instruction writes its destination |
| br_miss | input | 1 | Branch resolved as mispredicted this cycle |
| fwd_a | output | 2 | Operand A bypass select |
| fwd_b | output | 2 | Operand B bypass select |
| pc_hold | output | 1 | Keep the program counter unchanged |
| fd_hold | output | 1 | Keep the fetch/decode register unchanged |
| dx_bubble | output | 1 | Load zeroed control into the decode/execute register |
| fd_flush | output | 1 | Invalidate the fetch/decode register |
| dx_flush | output | 1 | Invalidate the decode/execute register |

## Verification
The assertions check the following on every cycle. Selects never take the illegal value. A selected producer must have its write enable set, and a load in execute/memory is never forwarded from there. Register 0 never produces a bypass. A stall is never followed by a second stall. A mispredict always flushes and never coexists with a hold. The precise priority between two matching producers, the exact conditions that start a load-use stall, and the re-arming of the stall two cycles later depend on specific input combinations. Only the bench's sweeps over a reduced register range, with their arithmetic model, show those.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] dx_rs1,
  input  logic [RW-1:0] dx_rs2,
  input  logic [RW-1:0] fd_rs1,
  input  logic [RW-1:0] fd_rs2,
  input  logic [RW-1:0] dx_rd,
  input  logic          dx_we,
  input  logic          dx_load,
  input  logic [RW-1:0] xm_rd,
  input  logic          xm_we,
  input  logic          xm_load,
  input  logic [RW-1:0] mw_rd,
  input  logic          mw_we,
  input  logic          br_miss,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_hold,
  output logic          fd_hold,
  output logic          dx_bubble,
  output logic          fd_flush,
  output logic          dx_flush
);
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_MW = 2'b01;
  localparam logic [1:0] SEL_XM = 2'b10;
  localparam logic [RW-1:0] R0 = '0;

  logic xm_ok, mw_ok, dx_ok;
  logic use_hit, stall, stall_q;

  assign xm_ok = xm_we && !xm_load && (xm_rd != R0);
  assign mw_ok = mw_we && (mw_rd != R0);
  assign dx_ok = dx_we && dx_load && (dx_rd != R0);

  function automatic logic [1:0] pick(input logic [RW-1:0] src);
    if (xm_ok && xm_rd == src)      pick = SEL_XM;
    else if (mw_ok && mw_rd == src) pick = SEL_MW;
    else                            pick = SEL_RF;
  endfunction

  assign fwd_a = pick(dx_rs1);
  assign fwd_b = pick(dx_rs2);

  assign use_hit = dx_ok && ((dx_rd == fd_rs1) || (dx_rd == fd_rs2));
  assign stall   = use_hit && !br_miss && !stall_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;

  assign pc_hold   = stall;
  assign fd_hold   = stall;
  assign dx_bubble = stall;
  assign fd_flush  = br_miss;
  assign dx_flush  = br_miss;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] dx_rs1,
  input logic [RW-1:0] xm_rd,
  input logic          xm_we,
  input logic          xm_load,
  input logic          mw_we,
  input logic          br_miss,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          pc_hold,
  input logic          fd_hold,
  input logic          dx_bubble,
  input logic          fd_flush,
  input logic          dx_flush
);
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) fwd_a != 2'b11 && fwd_b != 2'b11); // R3
  AST_XM_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n) (fwd_a == 2'b10 || fwd_b == 2'b10) |-> xm_we); // R5
  AST_MW_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n) (fwd_a == 2'b01 || fwd_b == 2'b01) |-> mw_we); // R5
  AST_NO_LOAD_XM: assert property (@(posedge clk) disable iff (!rst_n) xm_load |-> (fwd_a != 2'b10 && fwd_b != 2'b10)); // R7
  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n) (dx_rs1 == '0) |-> fwd_a == 2'b00); // R6
  AST_XM_NOT_R0: assert property (@(posedge clk) disable iff (!rst_n) (xm_rd == '0) |-> (fwd_a != 2'b10 && fwd_b != 2'b10)); // R6
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) (pc_hold || fd_hold || dx_bubble) |=> !(pc_hold || fd_hold || dx_bubble)); // R9
  AST_MISS_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n) br_miss |-> (fd_flush && dx_flush)); // R10
  AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n) br_miss |-> !(pc_hold || fd_hold || dx_bubble)); // R11
endmodule

bind hazard_unit hazard_unit_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dx_rs1(dx_rs1), .xm_rd(xm_rd), .xm_we(xm_we),
  .xm_load(xm_load), .mw_we(mw_we), .br_miss(br_miss), .fwd_a(fwd_a),
  .fwd_b(fwd_b), .pc_hold(pc_hold), .fd_hold(fd_hold), .dx_bubble(dx_bubble),
  .fd_flush(fd_flush), .dx_flush(dx_flush)
);

// File: tb/sim_hazard_unit.sv
`timescale 1ns/1ps
module sim_hazard_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] dx_rs1, dx_rs2, fd_rs1, fd_rs2, dx_rd, xm_rd, mw_rd;
  logic dx_we, dx_load, xm_we, xm_load, mw_we, br_miss;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, fd_hold, dx_bubble, fd_flush, dx_flush;
  int nchk = 0, nerr = 0, cyc = 0;
  bit prev_stall = 1'b0;

  always #2.5 clk = ~clk;

  hazard_unit u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  function automatic logic [1:0] ref_sel(input logic [4:0] s, xr, input logic xw, xl,
                                         input logic [4:0] mr, input logic mw);
    if (s != 0 && xw && !xl && xr == s) return 2'b10;
    if (s != 0 && mw && mr == s)        return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    {dx_rs1, dx_rs2, fd_rs1, fd_rs2, dx_rd, xm_rd, mw_rd} = '0;
    {dx_we, dx_load, xm_we, xm_load, mw_we, br_miss} = '0;
  endtask

  task automatic stall_vec(input logic [4:0] a, b, d, input logic we, ld, miss, input string req);
    bit lu, st;
    @(negedge clk);
    fd_rs1 = a; fd_rs2 = b; dx_rd = d; dx_we = we; dx_load = ld; br_miss = miss;
    #1;
    lu = ld && we && d != 0 && (d == a || d == b);
    st = lu && !miss && !prev_stall;
    chk({req, " pc_hold"}, pc_hold, st);
    chk({req, " fd_hold"}, fd_hold, st);
    chk({req, " dx_bubble"}, dx_bubble, st);
    chk("R10 fd_flush", fd_flush, miss);
    chk("R10 dx_flush", dx_flush, miss);
    prev_stall = st;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 fwd_a", fwd_a, 0); chk("R1 fwd_b", fwd_b, 0);
    chk("R1 hold", {pc_hold, fd_hold, dx_bubble}, 0);
    chk("R1 flush", {fd_flush, dx_flush}, 0);

    // R2 R3 R4 R5 R6 R7: sweep forwarding over registers 0..3
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      idle();
      dx_rs1 = 5'(i[1:0]); dx_rs2 = 5'(i[9] ? i[1:0] : ~i[1:0] & 2'b11);
      xm_rd = 5'(i[3:2]); mw_rd = 5'(i[5:4]);
      xm_we = i[6]; mw_we = i[7]; xm_load = i[8];
      #1;
      chk("R2/R3/R4/R5/R6/R7 fwd_a", fwd_a, ref_sel(dx_rs1, xm_rd, xm_we, xm_load, mw_rd, mw_we));
      chk("R2/R3/R4/R5/R6/R7 fwd_b", fwd_b, ref_sel(dx_rs2, xm_rd, xm_we, xm_load, mw_rd, mw_we));
    end

    // Directed priority and load cases
    @(negedge clk); idle(); dx_rs1 = 5'd9; xm_rd = 5'd9; mw_rd = 5'd9; xm_we = 1; mw_we = 1; #1;
    chk("R4 younger wins", fwd_a, 2);
    xm_load = 1; #1;
    chk("R7 load falls to mw", fwd_a, 1);
    mw_we = 0; #1;
    chk("R7 load falls to rf", fwd_a, 0);

    // R8 R9 R10 R11: sweep stall/flush over registers 0..3
    @(negedge clk); idle(); prev_stall = 1'b0;
    for (int i = 0; i < 512; i++)
      stall_vec(5'(i[1:0]), 5'(i[3:2]), 5'(i[5:4]), i[6], i[7], i[8], "R8/R9/R11");

    // R9: same hazard held three cycles stalls, releases, stalls again
    @(negedge clk); idle(); prev_stall = 1'b0;
    stall_vec(5'd7, 5'd0, 5'd0, 1, 1, 0, "R9 idle");
    stall_vec(5'd7, 5'd0, 5'd7, 1, 1, 0, "R8 first");
    stall_vec(5'd7, 5'd0, 5'd7, 1, 1, 0, "R9 second");
    stall_vec(5'd7, 5'd0, 5'd7, 1, 1, 0, "R9 rearm");
    stall_vec(5'd0, 5'd7, 5'd7, 1, 1, 1, "R11 miss");
    stall_vec(5'd0, 5'd0, 5'd0, 1, 1, 0, "R6 r0 load");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule